// File: doc/BRIEF.md
# Configurable Digital Watchdog

This block is a reloadable down-counting watchdog. Each pulse of a prescaled count tick takes one step off a 6-bit counter while the watchdog is active. Once the count is used up the block raises a reset request, and the internal core reset then stays asserted for a selectable start-up delay. Software postpones the timeout by writing a fresh reload value. Two strap options set how activation works. In hardware mode the watchdog runs from reset. In software mode it stays idle until a write sets its enable bit, and after that only a reset clears the enable.

The block also resolves a STOP request from the core into either a true STOP, in which the counter freezes, or a WAIT, in which counting carries on. A running watchdog normally turns STOP into WAIT. When the external stop-control strap is set, the level of an external pin makes the choice instead. A wake event, normally an interrupt, ends STOP or WAIT, and counting resumes from the frozen value. The power-on release and every watchdog timeout go through the same stretch of 2048 or 32768 clock cycles.

Top module: `wdog_top`

## Requirements
- R1: After `rst_n` is released, `core_rst_o` stays high for exactly 2048 clock cycles, or 32768 when `opt_long_delay_i` is 1. During and after reset `count_o` reads 8'hFE and `rst_req_o` is low.
- R2: `count_o` shows the counter in bits [7:2], with bit 1 reading 1 and bit 0 reading 0. Each tick while active, not frozen and not in core reset lowers the counter by one.
- R3: A tick that finds the counter at 1 or 0 sets it to 0 and raises `rst_req_o` in the next cycle. So a reload value V expires on tick max(V,1). `rst_req_o` stays high until the next tick and drops at that tick.
- R4: The delay from R1 starts at the tick that ends the reset request, and `core_rst_o` is high for the whole request plus the delay. While `core_rst_o` is high the counter returns to 6'h3F (reads 8'hFE) and the software enable is cleared.
- R5: A write while active loads `wr_data_i[7:2]` into the counter, and the new value is visible in the next cycle. A write takes priority over a tick in the same cycle.
- R6: With `opt_hw_act_i`=0 the watchdog is inactive until a write with `wr_data_i[1]`=1. Until then, ticks and writes with bit 1 at 0 leave `count_o` unchanged. The enabling write also loads its reload value.
- R7: Once enabled, a write with `wr_data_i[1]`=0 reloads the counter but does not disable the watchdog.
- R8: With `opt_hw_act_i`=1 the watchdog counts from the end of core reset without any write.
- R9: A `stop_req_i` pulse while the watchdog is inactive gives a true STOP (`stop_o`=1) in the next cycle.
- R10: A `stop_req_i` pulse while active with `opt_ext_stop_i`=0 gives WAIT (`wait_o`=1, `stop_o`=0), and ticks keep lowering the counter. `stop_o` and `wait_o` are never both high.
- R11: While active with `opt_ext_stop_i`=1, a stop request gives WAIT when `stop_pin_i` is 0. When the pin is 1 it gives STOP, and ticks leave the counter frozen.
- R12: `wake_i` returns the block to running in the next cycle, and the counter resumes from its frozen value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (oscillator rate) |
| rst_n | input | 1 | Asynchronous active-low reset source |
| tick_i | input | 1 | One-cycle prescaled count tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data: [7:2] reload, [1] enable, [0] unused |
| stop_req_i | input | 1 | STOP request pulse from the core |
| stop_pin_i | input | 1 | External stop-control pin level |
| wake_i | input | 1 | Wake event ending STOP or WAIT |
| opt_hw_act_i | input | 1 | 1: hardware activation, 0: software activation |
| opt_ext_stop_i | input | 1 | 1: pin decides STOP vs WAIT when active |
| opt_long_delay_i | input | 1 | 1: 32768-cycle start-up delay, 0: 2048 |
| rst_req_o | output | 1 | Watchdog reset request, one tick period long |
| core_rst_o | output | 1 | Stretched internal reset |
| stop_o | output | 1 | True STOP in effect (counter frozen) |
| wait_o | output | 1 | WAIT in effect |
| count_o | output | 8 | Counter readback {count, 1, 0} |

## Verification
The hardest state to reach from the ports is a true STOP while the watchdog is running. It needs an active watchdog, the external stop-control strap set and the pin held high when the request arrives. The stimulus reaches it on purpose: it enables the watchdog, first passes through the pin-low WAIT case, then raises the pin and applies ticks to show that the counter does not move until a wake. Timeout lengths are checked with random reload values and random early kicks. Each timeout is followed across the one-tick request window and the full stretch, in both delay settings.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        SEQ_STRETCH = 2'd0,
        SEQ_RUN     = 2'd1,
        SEQ_REQ     = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_WAIT = 2'd1,
        PWR_STOP = 2'd2
    } pwr_e;
endpackage

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             tick_i,
    input  logic             frozen_i,
    input  logic             hw_act_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_val_i,
    input  logic             wr_enable_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             active_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sw_en;
    } cnt_state_t;

    localparam logic [CNT_W-1:0] CNT_INIT = '1;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    cnt_state_t st_d, st_q;
    logic       act;
    logic       exp_d;

    always_comb begin
        st_d  = st_q;
        act   = hw_act_i | st_q.sw_en;
        exp_d = 1'b0;
        if (hold_i) begin
            st_d.cnt   = CNT_INIT;
            st_d.sw_en = 1'b0;
        end else if (wr_en_i && (act || wr_enable_i)) begin
            st_d.cnt = wr_val_i;
            if (wr_enable_i) begin
                st_d.sw_en = 1'b1;
            end
        end else if (tick_i && act && !frozen_i) begin
            if (st_q.cnt <= CNT_ONE) begin
                st_d.cnt = '0;
                exp_d    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= CNT_INIT;
            st_q.sw_en <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign active_o = act;
    assign expire_o = exp_d;
endmodule

// File: rtl/wdog_power.sv
module wdog_power
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic stop_req_i,
    input  logic wake_i,
    input  logic active_i,
    input  logic ext_ctl_i,
    input  logic pin_i,
    output logic stop_o,
    output logic wait_o
);
    pwr_e mode_d, mode_q;
    logic true_stop;

    always_comb begin
        mode_d    = mode_q;
        true_stop = !active_i || (ext_ctl_i && pin_i);
        if (hold_i || wake_i) begin
            mode_d = PWR_RUN;
        end else if (stop_req_i && mode_q == PWR_RUN) begin
            mode_d = true_stop ? PWR_STOP : PWR_WAIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= PWR_RUN;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign stop_o = (mode_q == PWR_STOP);
    assign wait_o = (mode_q == PWR_WAIT);
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
    import wdog_pkg::*;
#(
    parameter int DLY_SHORT = 2048,
    parameter int DLY_LONG  = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic tick_i,
    input  logic long_i,
    output logic hold_o,
    output logic req_o
);
    localparam int DLY_W = $clog2(DLY_LONG);
    localparam logic [DLY_W-1:0] LAST_S = DLY_W'(DLY_SHORT - 1);
    localparam logic [DLY_W-1:0] LAST_L = DLY_W'(DLY_LONG - 1);

    typedef struct packed {
        seq_e             ph;
        logic [DLY_W-1:0] dly;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [DLY_W-1:0] last;

    always_comb begin
        st_d = st_q;
        last = long_i ? LAST_L : LAST_S;
        case (st_q.ph)
            SEQ_STRETCH: begin
                if (st_q.dly == last) begin
                    st_d.ph  = SEQ_RUN;
                    st_d.dly = '0;
                end else begin
                    st_d.dly = st_q.dly + DLY_W'(1);
                end
            end
            SEQ_RUN: begin
                if (expire_i) begin
                    st_d.ph = SEQ_REQ;
                end
            end
            SEQ_REQ: begin
                if (tick_i) begin
                    st_d.ph  = SEQ_STRETCH;
                    st_d.dly = '0;
                end
            end
            default: begin
                st_d.ph  = SEQ_STRETCH;
                st_d.dly = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= SEQ_STRETCH;
            st_q.dly <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = (st_q.ph != SEQ_RUN);
    assign req_o  = (st_q.ph == SEQ_REQ);
endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
    parameter int CNT_W     = 6,
    parameter int DLY_SHORT = 2048,
    parameter int DLY_LONG  = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [CNT_W+1:0] wr_data_i,
    input  logic             stop_req_i,
    input  logic             stop_pin_i,
    input  logic             wake_i,
    input  logic             opt_hw_act_i,
    input  logic             opt_ext_stop_i,
    input  logic             opt_long_delay_i,
    output logic             rst_req_o,
    output logic             core_rst_o,
    output logic             stop_o,
    output logic             wait_o,
    output logic [CNT_W+1:0] count_o
);
    logic             hold;
    logic             expire;
    logic             active;
    logic [CNT_W-1:0] cnt;
    logic             unused_wr_bit0;

    assign unused_wr_bit0 = wr_data_i[0];

    wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (hold),
        .tick_i      (tick_i),
        .frozen_i    (stop_o),
        .hw_act_i    (opt_hw_act_i),
        .wr_en_i     (wr_en_i),
        .wr_val_i    (wr_data_i[CNT_W+1:2]),
        .wr_enable_i (wr_data_i[1]),
        .cnt_o       (cnt),
        .active_o    (active),
        .expire_o    (expire)
    );

    wdog_power u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold),
        .stop_req_i (stop_req_i),
        .wake_i     (wake_i),
        .active_i   (active),
        .ext_ctl_i  (opt_ext_stop_i),
        .pin_i      (stop_pin_i),
        .stop_o     (stop_o),
        .wait_o     (wait_o)
    );

    wdog_seq #(.DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .tick_i   (tick_i),
        .long_i   (opt_long_delay_i),
        .hold_o   (hold),
        .req_o    (rst_req_o)
    );

    assign core_rst_o = hold;
    assign count_o    = {cnt, 2'b10};
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             wr_en_i,
    input logic             opt_hw_act_i,
    input logic             rst_req_o,
    input logic             core_rst_o,
    input logic             stop_o,
    input logic             wait_o,
    input logic [CNT_W+1:0] count_o
);
    localparam logic [CNT_W+1:0] VIEW_INIT = {{CNT_W{1'b1}}, 2'b10};

    p_req_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o && tick_i |=> !rst_req_o);

    p_req_in_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> core_rst_o);

    p_core_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> (count_o == VIEW_INIT) && !stop_o && !wait_o);

    p_mode_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_o && wait_o));

    p_stop_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o && !wr_en_i |=> $stable(count_o));

    p_hw_counts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        opt_hw_act_i && tick_i && !core_rst_o && !stop_o && !wr_en_i
            && (count_o[CNT_W+1:2] > CNT_W'(1))
        |=> count_o[CNT_W+1:2] == $past(count_o[CNT_W+1:2]) - CNT_W'(1));
endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       stop_req_i = 1'b0;
    logic       stop_pin_i = 1'b0;
    logic       wake_i = 1'b0;
    logic       opt_hw_act_i = 1'b0;
    logic       opt_ext_stop_i = 1'b0;
    logic       opt_long_delay_i = 1'b0;
    logic       rst_req_o, core_rst_o, stop_o, wait_o;
    logic [7:0] count_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdog_top u0 (.*);

    function automatic int exp_ticks(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int view(input int v);
        return ((v & 63) << 2) | 2;
    endfunction

    function automatic logic [7:0] wcode(input int v, input bit en);
        return 8'(((v & 63) << 2) | (en ? 2 : 0));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en_i = 1'b1; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic tick(output bit req_seen);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        req_seen = rst_req_o;
        repeat (11) @(negedge clk);
    endtask

    task automatic stop_pulse();
        stop_req_i = 1'b1;
        @(negedge clk);
        stop_req_i = 1'b0;
    endtask

    task automatic wake_pulse();
        wake_i = 1'b1;
        @(negedge clk);
        wake_i = 1'b0;
    endtask

    task automatic measure_core(input string tag, input int lim);
        int n = 0;
        while (core_rst_o && n < 40000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, n, lim);
    endtask

    task automatic finish_request(input int lim);
        chk("R3 request held until next tick", int'(rst_req_o), 1);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        chk("R3 request drops at tick", int'(rst_req_o), 0);
        chk("R4 core reset held after request", int'(core_rst_o), 1);
        measure_core("R4 stretch after timeout", lim);
        chk("R4 counter reinit", int'(count_o), 8'hFE);
    endtask

    initial begin
        bit r;
        int v, k, n;
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        chk("R1 count in reset", int'(count_o), 8'hFE);
        chk("R1 no request in reset", int'(rst_req_o), 0);
        rst_n = 1'b1;
        measure_core("R1 power-on stretch short", 2048);
        chk("R1 count after reset", int'(count_o), 8'hFE);

        // software mode, inactive
        repeat (3) tick(r);
        chk("R6 ticks ignored while inactive", int'(count_o), 8'hFE);
        wr(wcode(42, 0));
        chk("R6 write without enable ignored", int'(count_o), 8'hFE);
        stop_pulse();
        chk("R9 true STOP while inactive", int'(stop_o), 1);
        wake_pulse();
        chk("R12 wake leaves STOP", int'(stop_o), 0);

        wr(wcode(20, 1));
        chk("R5 R6 enabling write loads", int'(count_o), view(20));
        tick(r);
        chk("R2 decrement", int'(count_o), view(19));
        wr(wcode(10, 0));
        chk("R7 reload without enable bit", int'(count_o), view(10));
        tick(r);
        chk("R7 still counting", int'(count_o), view(9));

        // WAIT with watchdog active
        stop_pulse();
        chk("R10 stop becomes wait", int'(wait_o), 1);
        chk("R10 no true stop", int'(stop_o), 0);
        tick(r);
        chk("R10 counts in wait", int'(count_o), view(8));
        wake_pulse();
        chk("R12 wake leaves wait", int'(wait_o), 0);

        // external stop control
        opt_ext_stop_i = 1'b1; stop_pin_i = 1'b0;
        stop_pulse();
        chk("R11 pin low gives wait", int'(wait_o), 1);
        wake_pulse();
        stop_pin_i = 1'b1;
        stop_pulse();
        chk("R11 pin high gives stop", int'(stop_o), 1);
        repeat (3) tick(r);
        chk("R11 frozen in stop", int'(count_o), view(8));
        wake_pulse();
        tick(r);
        chk("R12 resumes from frozen", int'(count_o), view(7));
        opt_ext_stop_i = 1'b0; stop_pin_i = 1'b0;

        // random reloads, kicks and timeouts
        for (int t = 0; t < 8; t++) begin
            v = $urandom_range(0, 15);
            wr(wcode(v, 1));
            k = $urandom_range(0, exp_ticks(v) - 1);
            for (int i = 0; i < k; i++) tick(r);
            chk("R5 no timeout before kick", int'(rst_req_o), 0);
            chk("R2 count after random ticks", int'(count_o), view(v - k));
            v = $urandom_range(0, 15);
            wr(wcode(v, 1));
            chk("R5 kick reloads", int'(count_o), view(v));
            n = 0; r = 0;
            while (!r && n < 70) begin
                tick(r);
                n++;
            end
            chk("R3 ticks to timeout", n, exp_ticks(v));
            finish_request(2048);
            tick(r);
            chk("R4 enable cleared by timeout", int'(count_o), 8'hFE);
        end

        // hardware activation with long delay
        opt_hw_act_i = 1'b1; opt_long_delay_i = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        measure_core("R1 power-on stretch long", 32768);
        tick(r);
        chk("R8 counts without write", int'(count_o), view(62));
        wr(wcode(0, 0));
        tick(r);
        chk("R3 zero reload expires on first tick", int'(r), 1);
        finish_request(32768);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1-timeout run hung actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule